// File: doc/BRIEF.md
# Transmit User-Bit Double Buffer

This block keeps the user bits that a serial digital-audio transmitter sends, one bit per subframe. The host fills a staging buffer one byte at a time. It first loads a byte address into an address register, then writes bytes through a data register. The address advances after every byte the block accepts. When the last byte of the selected block length has been written, the staging buffer counts as full.

At the next block boundary, which is the subframe that wraps the bit index back to zero and so carries the block-start (Z) preamble, the full staging content is copied into the active buffer. The transmitter then shifts the new bits out. Two sticky flags report this exchange to the host. "Updated" means the active buffer has taken the data and the staging buffer is free again. "Full" means the staging buffer has been filled completely. Both flags clear when the status register is read. Each flag can raise the interrupt output only if its own mask bit is set.

The host port has a 2-bit register select. Select 0 is the byte address, select 1 is the staging data byte, select 2 is the status register and select 3 is the control register. Register reads are combinational.

Top module: `ub_txbuf`

## Requirements
- R1: Control bit 2 selects the block length: 0 gives 384 user bits and 1 gives 768. In 768 mode, blk_first is high again after exactly 768 subframe ticks.
- R2: blk_first is high exactly while the bit index is 0. That bit goes out with the block-start preamble, and bit index 0 is reset to right after every block transfer.
- R3: A write to select 0 sets the byte address (bits 6:0). A write to select 1 stores the byte at that address and then increments the address. A write to select 1 whose address is at or beyond the block's byte count (48 or 96) is dropped and leaves the address unchanged. A read of select 0 returns the address, and a read of select 1 returns the staging byte at that address.
- R4: ubit equals bit (index mod 8) of active byte (index / 8), so each byte goes out LSB first. Each cycle with sf_tick high advances the index by one, and the index wraps to 0 after the last bit of the selected length.
- R5: Writing the byte at the last address of the block marks the staging buffer full. The same write sets the full flag, which is status bit 1.
- R6: While the staging buffer is full, data writes are ignored: the byte is not stored and the address does not move. This lasts until the transfer to the active buffer.
- R7: On an sf_tick that wraps the index to 0 with the staging buffer full, the active buffer takes the staging content, the staging buffer becomes not full, and the updated flag (status bit 0) is set. Without a full staging buffer the active content is kept.
- R8: A cycle with hst_rd high and select 2 returns the flags and clears both of them after that cycle. A flag event in that same cycle leaves its flag set.
- R9: irq is high when the updated flag is set with control bit 0, or when the full flag is set with control bit 1.
- R10: After reset the flags, control bits, address, bit index and both buffers are all zero. This gives irq low, ubit low and blk_first high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 2 | Register select: 0 address, 1 data, 2 status, 3 control |
| hst_wr | input | 1 | Register write strobe |
| hst_rd | input | 1 | Register read strobe (clears the status flags on select 2) |
| hst_wdata | input | 8 | Write data |
| hst_rdata | output | 8 | Read data of the selected register |
| sf_tick | input | 1 | One pulse per subframe: consume one user bit |
| ubit | output | 1 | User bit for the current subframe |
| blk_first | output | 1 | Current bit is the first of a block |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench issues a status read in the very cycle the block transfer sets the updated flag. A design that let the read win would lose that event and leave the host waiting forever. It writes into a full staging buffer and reads the byte back; a design that did not block those writes would corrupt the block that is waiting to be sent. It counts ticks between block starts after switching to the long mode, which catches a wrap at the wrong length. It also tries writes at out-of-range addresses in the short mode, which a design without the range guard would store in the unused half.

// File: rtl/ub_txbuf_pkg.sv
package ub_txbuf_pkg;
   typedef enum logic [1:0] {
      UB_REG_ADDR = 2'd0,
      UB_REG_DATA = 2'd1,
      UB_REG_STAT = 2'd2,
      UB_REG_CTRL = 2'd3
   } ub_reg_e;

   localparam int CTL_MASK_UPD  = 0;
   localparam int CTL_MASK_FULL = 1;
   localparam int CTL_LONG      = 2;
   localparam int CTL_W         = 3;

   localparam int ST_UPD  = 0;
   localparam int ST_FULL = 1;
endpackage

// File: rtl/ub_txbuf_stage.sv
module ub_txbuf_stage #(
   parameter int LONG_BYTES  = 96,
   parameter int SHORT_BYTES = 48,
   parameter int AW          = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    addr_we,
   input  logic                    data_we,
   input  logic                    long_mode,
   input  logic                    load,
   input  logic [7:0]              wdata,
   output logic [AW-1:0]           addr,
   output logic                    full,
   output logic                    full_evt,
   output logic [7:0]              rbyte,
   output logic [LONG_BYTES*8-1:0] img
);
   localparam int PW = AW + 3;

   logic [AW-1:0] nb;
   logic          wr_ok;
   logic          last;

   assign nb       = long_mode ? AW'(LONG_BYTES) : AW'(SHORT_BYTES);
   assign wr_ok    = data_we && !full && (addr < nb);
   assign last     = (addr == nb - AW'(1));
   assign full_evt = wr_ok && last;

   generate
      for (genvar g = 0; g < LONG_BYTES; g++) begin : g_byte
         logic [7:0] byte_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               byte_q <= '0;
            else if (wr_ok && addr == AW'(g))
               byte_q <= wdata;
         end
         assign img[g*8 +: 8] = byte_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (addr_we)
         addr <= wdata[AW-1:0];
      else if (wr_ok)
         addr <= addr + AW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         full <= 1'b0;
      else if (load)
         full <= 1'b0;
      else if (full_evt)
         full <= 1'b1;
   end

   assign rbyte = (addr < AW'(LONG_BYTES)) ? img[{addr, 3'b000} +: 8] : 8'h00;

   logic unused_pw;
   assign unused_pw = (PW == 0);
endmodule

// File: rtl/ub_txbuf_active.sv
module ub_txbuf_active #(
   parameter int LONG_BITS  = 768,
   parameter int SHORT_BITS = 384,
   parameter int IW         = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 long_mode,
   input  logic                 stg_full,
   input  logic [LONG_BITS-1:0] img,
   output logic                 ubit,
   output logic                 first,
   output logic                 load
);
   logic [IW-1:0]        idx;
   logic [IW-1:0]        lenm1;
   logic [LONG_BITS-1:0] act;
   logic                 wrap;

   generate
      if (SHORT_BITS == LONG_BITS) begin : g_fixed
         assign lenm1 = IW'(LONG_BITS - 1);
         logic unused_mode;
         assign unused_mode = long_mode;
      end else begin : g_switch
         assign lenm1 = long_mode ? IW'(LONG_BITS - 1) : IW'(SHORT_BITS - 1);
      end
   endgenerate

   assign wrap = tick && (idx >= lenm1);
   assign load = wrap && stg_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (tick)
         idx <= wrap ? '0 : idx + IW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act <= '0;
      else if (load)
         act <= img;
   end

   assign ubit  = act[idx];
   assign first = (idx == '0);
endmodule

// File: rtl/ub_txbuf_regs.sv
module ub_txbuf_regs
   import ub_txbuf_pkg::*;
#(
   parameter int AW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    sel,
   input  logic          wr,
   input  logic          rd,
   input  logic [7:0]    wdata,
   input  logic          load,
   input  logic          full_evt,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    rbyte,
   output logic          long_mode,
   output logic [7:0]    rdata,
   output logic          irq,
   output logic          flag_upd,
   output logic          flag_full,
   output logic [1:0]    msk
);
   logic [CTL_W-1:0] ctl_q;
   logic             clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (wr && sel == UB_REG_CTRL)
         ctl_q <= wdata[CTL_W-1:0];
   end

   assign clr = rd && (sel == UB_REG_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_upd  <= 1'b0;
         flag_full <= 1'b0;
      end else begin
         flag_upd  <= load     | (flag_upd  & ~clr);
         flag_full <= full_evt | (flag_full & ~clr);
      end
   end

   always_comb begin
      rdata = '0;
      case (ub_reg_e'(sel))
         UB_REG_ADDR: rdata[AW-1:0] = addr;
         UB_REG_DATA: rdata = rbyte;
         UB_REG_STAT: begin
            rdata[ST_UPD]  = flag_upd;
            rdata[ST_FULL] = flag_full;
         end
         default:     rdata[CTL_W-1:0] = ctl_q;
      endcase
   end

   assign long_mode = ctl_q[CTL_LONG];
   assign msk       = {ctl_q[CTL_MASK_FULL], ctl_q[CTL_MASK_UPD]};
   assign irq       = (flag_upd & msk[0]) | (flag_full & msk[1]);
endmodule

// File: rtl/ub_txbuf.sv
module ub_txbuf
   import ub_txbuf_pkg::*;
#(
   parameter int SHORT_BITS = 384,
   parameter int LONG_BITS  = 768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] hst_sel,
   input  logic       hst_wr,
   input  logic       hst_rd,
   input  logic [7:0] hst_wdata,
   output logic [7:0] hst_rdata,
   input  logic       sf_tick,
   output logic       ubit,
   output logic       blk_first,
   output logic       irq
);
   localparam int LONG_BYTES  = LONG_BITS / 8;
   localparam int SHORT_BYTES = SHORT_BITS / 8;
   localparam int AW          = $clog2(LONG_BYTES + 1);
   localparam int IW          = $clog2(LONG_BITS);

   generate
      if (LONG_BITS % 8 != 0 || SHORT_BITS % 8 != 0) begin : g_bad_align
         $error("block lengths must be whole bytes");
      end
      if (SHORT_BITS > LONG_BITS || SHORT_BITS < 8) begin : g_bad_order
         $error("short length must be between 8 and the long length");
      end
      if (AW > 8) begin : g_bad_addr
         $error("byte address must fit the 8-bit host data path");
      end
   endgenerate

   logic          long_w;
   logic          load_w;
   logic          stg_full_w;
   logic          full_evt_w;
   logic          flag_upd_w;
   logic          flag_full_w;
   logic [1:0]    msk_w;
   logic [AW-1:0] addr_w;
   logic [7:0]    rbyte_w;
   logic [LONG_BITS-1:0] img_w;

   ub_txbuf_stage #(
      .LONG_BYTES (LONG_BYTES),
      .SHORT_BYTES(SHORT_BYTES),
      .AW         (AW)
   ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_we  (hst_wr && hst_sel == UB_REG_ADDR),
      .data_we  (hst_wr && hst_sel == UB_REG_DATA),
      .long_mode(long_w),
      .load     (load_w),
      .wdata    (hst_wdata),
      .addr     (addr_w),
      .full     (stg_full_w),
      .full_evt (full_evt_w),
      .rbyte    (rbyte_w),
      .img      (img_w)
   );

   ub_txbuf_active #(
      .LONG_BITS (LONG_BITS),
      .SHORT_BITS(SHORT_BITS),
      .IW        (IW)
   ) u_active (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (sf_tick),
      .long_mode(long_w),
      .stg_full (stg_full_w),
      .img      (img_w),
      .ubit     (ubit),
      .first    (blk_first),
      .load     (load_w)
   );

   ub_txbuf_regs #(
      .AW(AW)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (hst_sel),
      .wr       (hst_wr),
      .rd       (hst_rd),
      .wdata    (hst_wdata),
      .load     (load_w),
      .full_evt (full_evt_w),
      .addr     (addr_w),
      .rbyte    (rbyte_w),
      .long_mode(long_w),
      .rdata    (hst_rdata),
      .irq      (irq),
      .flag_upd (flag_upd_w),
      .flag_full(flag_full_w),
      .msk      (msk_w)
   );
endmodule

// File: rtl/ub_txbuf_chk.sv
module ub_txbuf_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sf_tick,
   input logic       hst_rd,
   input logic [1:0] hst_sel,
   input logic       blk_first,
   input logic       irq,
   input logic       load,
   input logic       stg_full,
   input logic       flag_upd,
   input logic       flag_full,
   input logic [1:0] msk
);
   // R7: a transfer sets the updated flag, even against a status read
   assert_upd_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> flag_upd);

   // R7: transfer only on a tick with a full staging buffer
   assert_load_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (sf_tick && stg_full));

   // R6: staging stays full until a transfer takes it
   assert_hold_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stg_full && !load) |=> stg_full);

   // R2: the block restarts at bit 0 after a transfer
   assert_first_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> blk_first);

   // R8: a status read with no event clears the updated flag
   assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_rd && hst_sel == 2'd2 && !load) |=> !flag_upd);

   // R9: with both masks clear there is no interrupt
   assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (msk == 2'b00) |-> !irq);

   // R5: the staging buffer becoming full raises the full flag
   assert_full_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stg_full) |-> flag_full);
endmodule

bind ub_txbuf ub_txbuf_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sf_tick  (sf_tick),
   .hst_rd   (hst_rd),
   .hst_sel  (hst_sel),
   .blk_first(blk_first),
   .irq      (irq),
   .load     (load_w),
   .stg_full (stg_full_w),
   .flag_upd (flag_upd_w),
   .flag_full(flag_full_w),
   .msk      (msk_w)
);

// File: tb/ub_txbuf_test.sv
module ub_txbuf_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] hst_sel = 2'd0;
   logic       hst_wr = 1'b0;
   logic       hst_rd = 1'b0;
   logic [7:0] hst_wdata = 8'h00;
   logic [7:0] hst_rdata;
   logic       sf_tick = 1'b0;
   logic       ubit;
   logic       blk_first;
   logic       irq;

   int errs = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   ub_txbuf uut (
      .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_rd(hst_rd),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .sf_tick(sf_tick), .ubit(ubit),
      .blk_first(blk_first), .irq(irq)
   );

   // behavioural reference model
   logic [7:0] m_stg [96];
   logic [7:0] m_act [96];
   int   m_idx = 0;
   int   m_addr = 0;
   bit   m_full = 0;
   bit   m_fu = 0;
   bit   m_ff = 0;
   logic [2:0] m_ctl = 3'd0;

   always @(posedge clk) begin : model
      int  lenb;
      int  nb;
      bit  oldfull;
      bit  ld;
      bit  fe;
      bit  clr;
      if (!rst_n) begin
         for (int b = 0; b < 96; b++) begin
            m_stg[b] = 8'h00;
            m_act[b] = 8'h00;
         end
         m_idx = 0; m_addr = 0; m_full = 0; m_fu = 0; m_ff = 0; m_ctl = 3'd0;
      end else begin
         lenb = m_ctl[2] ? 768 : 384;
         nb = lenb / 8;
         oldfull = m_full;
         ld = 0;
         fe = 0;
         clr = hst_rd && hst_sel == 2'd2;
         if (sf_tick) begin
            if (m_idx >= lenb - 1) begin
               m_idx = 0;
               if (oldfull) begin
                  for (int b = 0; b < 96; b++) m_act[b] = m_stg[b];
                  ld = 1;
               end
            end else begin
               m_idx = m_idx + 1;
            end
         end
         if (hst_wr) begin
            case (hst_sel)
               2'd0: m_addr = int'(hst_wdata[6:0]);
               2'd1: if (!oldfull && m_addr < nb) begin
                  m_stg[m_addr] = hst_wdata;
                  if (m_addr == nb - 1) fe = 1;
                  m_addr = (m_addr + 1) % 128;
               end
               2'd3: m_ctl = hst_wdata[2:0];
               default: ;
            endcase
         end
         if (ld) m_full = 0;
         if (fe) m_full = 1;
         m_fu = ld | (m_fu & !clr);
         m_ff = fe | (m_ff & !clr);
      end
   end

   function automatic logic [7:0] exp_rdata();
      case (hst_sel)
         2'd0: return 8'(m_addr);
         2'd1: return (m_addr < 96) ? m_stg[m_addr] : 8'h00;
         2'd2: return {6'd0, m_ff, m_fu};
         default: return {5'd0, m_ctl};
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk("R4 ubit", 32'(ubit), 32'(m_act[m_idx / 8][m_idx % 8]));
         chk("R2 blk_first", 32'(blk_first), 32'(m_idx == 0));
         chk("R9 irq", 32'(irq), 32'((m_fu & m_ctl[0]) | (m_ff & m_ctl[1])));
         chk("R3 rdata", 32'(hst_rdata), 32'(exp_rdata()));
      end
   end

   task automatic cyc(input logic [1:0] s, input logic w, input logic r,
                      input logic [7:0] d, input logic t);
      @(negedge clk);
      hst_sel = s; hst_wr = w; hst_rd = r; hst_wdata = d; sf_tick = t;
      #2;
   endtask

   task automatic idle();
      cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
   endtask

   function automatic logic [7:0] pat1(input int i);
      return 8'(i * 29 + 7);
   endfunction

   function automatic logic [7:0] pat2(input int i);
      return 8'(i * 53 + 17);
   endfunction

   task automatic finish_up();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog: run did not complete");
      finish_up();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      cyc(2'd2, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R10 status after reset", 32'(hst_rdata), 32'h0);
      chk("R10 irq after reset", 32'(irq), 32'h0);
      chk("R10 blk_first after reset", 32'(blk_first), 32'h1);
      chk("R10 ubit after reset", 32'(ubit), 32'h0);
      cyc(2'd3, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R10 control after reset", 32'(hst_rdata), 32'h0);

      // short mode, both masks on; fill 48 bytes
      cyc(2'd3, 1'b1, 1'b0, 8'h03, 1'b0);
      cyc(2'd0, 1'b1, 1'b0, 8'h00, 1'b0);
      for (int i = 0; i < 47; i++) cyc(2'd1, 1'b1, 1'b0, pat1(i), 1'b0);
      cyc(2'd2, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R5 not full before last byte", 32'(hst_rdata), 32'h0);
      cyc(2'd1, 1'b1, 1'b0, pat1(47), 1'b0);
      cyc(2'd2, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R5 full flag after last byte", 32'(hst_rdata), 32'h2);
      chk("R9 irq from full flag", 32'(irq), 32'h1);

      // R6: writes to a full staging buffer are dropped
      cyc(2'd0, 1'b1, 1'b0, 8'd5, 1'b0);
      cyc(2'd1, 1'b1, 1'b0, 8'hAA, 1'b0);
      cyc(2'd1, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R6 byte unchanged while full", 32'(hst_rdata), 32'(pat1(5)));
      cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R6 address not advanced while full", 32'(hst_rdata), 32'd5);

      // advance to the last bit, then read status in the transfer cycle
      idle();
      n = 383 - m_idx;
      repeat (n) cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
      idle();
      chk("R4 index at last bit", 32'(m_idx), 32'd383);
      cyc(2'd2, 1'b0, 1'b1, 8'h00, 1'b1);
      chk("R8 read returns flags before clear", 32'(hst_rdata), 32'h2);
      cyc(2'd2, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R8 event in read cycle kept, full cleared", 32'(hst_rdata), 32'h1);
      chk("R7 first bit of new block", 32'(ubit), 32'(pat1(0)[0]));
      chk("R2 blk_first after transfer", 32'(blk_first), 32'h1);

      // walk through the block with irregular ticks
      for (int i = 0; i < 500; i++) cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'($urandom_range(0, 1)));
      cyc(2'd2, 1'b0, 1'b1, 8'h00, 1'b0);
      cyc(2'd2, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R8 flags cleared by read", 32'(hst_rdata), 32'h0);

      // long mode: fill 96 bytes while ticks run
      cyc(2'd3, 1'b1, 1'b0, 8'h07, 1'b0);
      cyc(2'd0, 1'b1, 1'b0, 8'h00, 1'b0);
      for (int i = 0; i < 96; i++) cyc(2'd1, 1'b1, 1'b0, pat2(i), 1'($urandom_range(0, 1)));
      idle();
      cyc(2'd2, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R5 full flag in long mode", 32'(hst_rdata) & 32'h2, 32'h2);

      // R1: ticks from one block start to the next
      cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
      idle();
      while (blk_first !== 1'b1) begin
         cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
         idle();
      end
      n = 0;
      do begin
         cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
         idle();
         n++;
      end while (blk_first !== 1'b1 && n < 2000);
      chk("R1 long block length", 32'(n), 32'd768);
      chk("R7 long block transferred", 32'(m_act[95]), 32'(pat2(95)));

      // R9: masking of the updated flag
      cyc(2'd3, 1'b1, 1'b0, 8'h04, 1'b0);
      cyc(2'd2, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R9 updated flag set", 32'(hst_rdata) & 32'h1, 32'h1);
      chk("R9 irq low with masks clear", 32'(irq), 32'h0);
      cyc(2'd3, 1'b1, 1'b0, 8'h05, 1'b0);
      idle();
      chk("R9 irq high with update mask", 32'(irq), 32'h1);
      cyc(2'd2, 1'b0, 1'b1, 8'h00, 1'b0);
      idle();
      chk("R8 irq low after status read", 32'(irq), 32'h0);

      // R3: range guard and auto-increment in short mode
      cyc(2'd3, 1'b1, 1'b0, 8'h00, 1'b0);
      cyc(2'd0, 1'b1, 1'b0, 8'd60, 1'b0);
      cyc(2'd1, 1'b1, 1'b0, 8'h55, 1'b0);
      cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R3 out-of-range write keeps address", 32'(hst_rdata), 32'd60);
      cyc(2'd1, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R3 out-of-range byte not stored", 32'(hst_rdata), 32'(pat2(60)));
      cyc(2'd0, 1'b1, 1'b0, 8'd40, 1'b0);
      cyc(2'd1, 1'b1, 1'b0, 8'h5A, 1'b0);
      cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R3 address increments", 32'(hst_rdata), 32'd41);
      cyc(2'd0, 1'b1, 1'b0, 8'd40, 1'b0);
      cyc(2'd1, 1'b0, 1'b0, 8'h00, 1'b0);
      chk("R3 byte read back", 32'(hst_rdata), 32'h5A);

      idle();
      idle();
      finish_up();
   end
endmodule